// File: doc/BRIEF.md
# Display-Mode CPU Access Gate

This block stands on the processor's path to the two display memories: the tile/pixel store (video RAM) and the sprite attribute table. Each cycle it decodes the processor address, looks at the 2-bit phase reported by the display sequencer, and decides whether the access may reach the memory. An allowed access produces the memory's read or write enable together with a region-relative offset. A blocked write is dropped. A blocked read is answered with an all-ones byte in place of the memory contents.

Addresses outside both display regions are not gated. Their read data comes back from an external return port. Read results of every kind arrive one cycle after the read strobe, which matches synchronous memories with one cycle of latency. When the display is switched off, the phase input is disregarded and both memories stay open.

Top module: `vid_access_gate`

## Requirements
- R1: Addresses 0x8000 to 0x9FFF inclusive select video RAM. The offset driven on `vid_addr` is the address minus 0x8000.
- R2: Addresses 0xFE00 to 0xFE9F inclusive select the sprite table. The offset driven on `spr_addr` is the address minus 0xFE00.
- R3: The phase encoding is 0 = horizontal blank, 1 = vertical blank, 2 = sprite search and 3 = pixel transfer. In phases 0 and 1, both memories accept reads and writes.
- R4: In phase 2 with the display on, the sprite table is locked and video RAM stays open.
- R5: In phase 3 with the display on, both memories are locked.
- R6: A write to a locked region asserts no write enable, in the same cycle as the strobe.
- R7: A read of a locked region asserts no read enable. In the cycle after the strobe, `cpu_rdata` shows 0xFF.
- R8: An allowed read asserts the matching read enable in the strobe cycle. In the following cycle, `cpu_rdata` shows that memory's returned data. The selection holds until the next read strobe.
- R9: An address outside both regions asserts no memory enable in any phase. A read there returns `ext_rdata` on `cpu_rdata` in the cycle after the strobe.
- R10: With `lcd_on` low, both memories accept all accesses whatever the phase.
- R11: During reset and after it, before any read, `cpu_rdata` follows `ext_rdata`.
- R12: `mem_wdata` always equals `cpu_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcd_on | input | 1 | Display enabled; when low no gating applies |
| mode | input | 2 | Current display phase from the sequencer |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Read data returned to the processor, one cycle after the strobe |
| vid_rd_en | output | 1 | Video RAM read enable |
| vid_wr_en | output | 1 | Video RAM write enable |
| vid_addr | output | 13 | Video RAM offset |
| vid_rdata | input | 8 | Video RAM read data |
| spr_rd_en | output | 1 | Sprite table read enable |
| spr_wr_en | output | 1 | Sprite table write enable |
| spr_addr | output | 8 | Sprite table offset |
| spr_rdata | input | 8 | Sprite table read data |
| mem_wdata | output | 8 | Write data shared by both memories |
| ext_rdata | input | 8 | Read data for addresses outside both regions |

## Verification
Enables, offsets and write data are combinational. They are due in the same cycle as the strobe, so the bench samples them 2 ns after it drives inputs on the falling edge. Read data passes one register. The bench keeps the source it expects from the previous strobe and compares `cpu_rdata` in the next cycle, after fresh random return data has been driven. A result held over idle cycles is therefore compared against the current value of the source that was selected, not against a stale value. Reset release passes two synchronizer stages, so stimulus begins only after several clean cycles.

// File: rtl/vgate_pkg.sv
package vgate_pkg;
  typedef enum logic [1:0] {
    PH_HBLANK = 2'd0,
    PH_VBLANK = 2'd1,
    PH_SEARCH = 2'd2,
    PH_XFER   = 2'd3
  } disp_phase_e;

  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_VID  = 2'd1,
    SRC_SPR  = 2'd2,
    SRC_FILL = 2'd3
  } rd_src_e;
endpackage

// File: rtl/vgate_rst_sync.sv
module vgate_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/vgate_region_dec.sv
module vgate_region_dec #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] VID_BASE = 16'h8000,
  parameter logic [ADDR_W-1:0] VID_LAST = 16'h9FFF,
  parameter logic [ADDR_W-1:0] SPR_BASE = 16'hFE00,
  parameter logic [ADDR_W-1:0] SPR_LAST = 16'hFE9F
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              vid_hit,
  output logic              spr_hit
);
  always_comb begin
    vid_hit = (addr >= VID_BASE) && (addr <= VID_LAST);
    spr_hit = (addr >= SPR_BASE) && (addr <= SPR_LAST);
  end
endmodule

// File: rtl/vgate_lock_policy.sv
module vgate_lock_policy
  import vgate_pkg::*;
(
  input  logic        lcd_on,
  input  disp_phase_e phase,
  output logic        vid_open,
  output logic        spr_open
);
  always_comb begin
    vid_open = 1'b1;
    spr_open = 1'b1;
    if (lcd_on) begin
      unique case (phase)
        PH_HBLANK, PH_VBLANK: begin
          vid_open = 1'b1;
          spr_open = 1'b1;
        end
        PH_SEARCH: begin
          vid_open = 1'b1;
          spr_open = 1'b0;
        end
        PH_XFER: begin
          vid_open = 1'b0;
          spr_open = 1'b0;
        end
        default: begin
          vid_open = 1'b0;
          spr_open = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/vgate_rd_return.sv
module vgate_rd_return
  import vgate_pkg::*;
#(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  rd_src_e           src_d,
  input  logic [DATA_W-1:0] vid_rdata,
  input  logic [DATA_W-1:0] spr_rdata,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic [DATA_W-1:0] cpu_rdata
);
  rd_src_e src_q;
  rd_src_e src_nxt;

  always_comb begin
    src_nxt = src_q;
    if (rd_fire) src_nxt = src_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= SRC_EXT;
    else        src_q <= src_nxt;
  end

  always_comb begin
    unique case (src_q)
      SRC_VID:  cpu_rdata = vid_rdata;
      SRC_SPR:  cpu_rdata = spr_rdata;
      SRC_FILL: cpu_rdata = FILL;
      default:  cpu_rdata = ext_rdata;
    endcase
  end

  p_fill_after_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && src_d == SRC_FILL) |=> (cpu_rdata == FILL));

  p_ext_after_outside_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && src_d == SRC_EXT) |=> (cpu_rdata == ext_rdata));
endmodule

// File: rtl/vid_access_gate.sv
module vid_access_gate
  import vgate_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] VID_BASE = 16'h8000,
  parameter logic [ADDR_W-1:0] VID_LAST = 16'h9FFF,
  parameter logic [ADDR_W-1:0] SPR_BASE = 16'hFE00,
  parameter logic [ADDR_W-1:0] SPR_LAST = 16'hFE9F,
  parameter int                VID_OFF_W = $clog2(int'(VID_LAST) - int'(VID_BASE) + 1),
  parameter int                SPR_OFF_W = $clog2(int'(SPR_LAST) - int'(SPR_BASE) + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lcd_on,
  input  logic [1:0]           mode,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic                 cpu_rd,
  input  logic                 cpu_wr,
  input  logic [DATA_W-1:0]    cpu_wdata,
  output logic [DATA_W-1:0]    cpu_rdata,
  output logic                 vid_rd_en,
  output logic                 vid_wr_en,
  output logic [VID_OFF_W-1:0] vid_addr,
  input  logic [DATA_W-1:0]    vid_rdata,
  output logic                 spr_rd_en,
  output logic                 spr_wr_en,
  output logic [SPR_OFF_W-1:0] spr_addr,
  input  logic [DATA_W-1:0]    spr_rdata,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    ext_rdata
);
  localparam logic [DATA_W-1:0] FILL_BYTE = '1;

  logic        rst_n_q;
  logic        vid_hit;
  logic        spr_hit;
  logic        vid_open;
  logic        spr_open;
  rd_src_e     src_d;
  disp_phase_e phase;

  assign phase = disp_phase_e'(mode);

  vgate_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_q)
  );

  vgate_region_dec #(
    .ADDR_W   (ADDR_W),
    .VID_BASE (VID_BASE),
    .VID_LAST (VID_LAST),
    .SPR_BASE (SPR_BASE),
    .SPR_LAST (SPR_LAST)
  ) u_dec (
    .addr    (cpu_addr),
    .vid_hit (vid_hit),
    .spr_hit (spr_hit)
  );

  vgate_lock_policy u_pol (
    .lcd_on   (lcd_on),
    .phase    (phase),
    .vid_open (vid_open),
    .spr_open (spr_open)
  );

  always_comb begin
    vid_rd_en = cpu_rd && vid_hit && vid_open;
    vid_wr_en = cpu_wr && vid_hit && vid_open;
    spr_rd_en = cpu_rd && spr_hit && spr_open;
    spr_wr_en = cpu_wr && spr_hit && spr_open;
    vid_addr  = VID_OFF_W'(cpu_addr - VID_BASE);
    spr_addr  = SPR_OFF_W'(cpu_addr - SPR_BASE);
    mem_wdata = cpu_wdata;
  end

  always_comb begin
    src_d = SRC_EXT;
    if (vid_hit)      src_d = vid_open ? SRC_VID : SRC_FILL;
    else if (spr_hit) src_d = spr_open ? SRC_SPR : SRC_FILL;
  end

  vgate_rd_return #(
    .DATA_W (DATA_W),
    .FILL   (FILL_BYTE)
  ) u_ret (
    .clk       (clk),
    .rst_n     (rst_n_q),
    .rd_fire   (cpu_rd),
    .src_d     (src_d),
    .vid_rdata (vid_rdata),
    .spr_rdata (spr_rdata),
    .ext_rdata (ext_rdata),
    .cpu_rdata (cpu_rdata)
  );

  p_regions_disjoint_r1: assert property (@(posedge clk) disable iff (!rst_n_q)
    $onehot0({vid_hit, spr_hit}));

  p_spr_locked_search_r4: assert property (@(posedge clk) disable iff (!rst_n_q)
    (spr_rd_en || spr_wr_en) |-> !(lcd_on && mode[1]));

  p_vid_locked_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n_q)
    (vid_rd_en || vid_wr_en) |-> !(lcd_on && mode == 2'd3));

  p_outside_no_enable_r9: assert property (@(posedge clk) disable iff (!rst_n_q)
    !(vid_hit || spr_hit) |-> !(vid_rd_en || vid_wr_en || spr_rd_en || spr_wr_en));

  p_display_off_open_r10: assert property (@(posedge clk) disable iff (!rst_n_q)
    (!lcd_on && cpu_wr && vid_hit) |-> vid_wr_en);
endmodule

// File: tb/vid_access_gate_bench.sv
`timescale 1ns/1ps
module vid_access_gate_bench;
  logic        clk;
  logic        rst_n;
  logic        lcd_on;
  logic [1:0]  mode;
  logic [15:0] cpu_addr;
  logic        cpu_rd;
  logic        cpu_wr;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata;
  logic        vid_rd_en;
  logic        vid_wr_en;
  logic [12:0] vid_addr;
  logic [7:0]  vid_rdata;
  logic        spr_rd_en;
  logic        spr_wr_en;
  logic [7:0]  spr_addr;
  logic [7:0]  spr_rdata;
  logic [7:0]  mem_wdata;
  logic [7:0]  ext_rdata;

  int checks;
  int failures;
  int pend_src;

  vid_access_gate u_vid_access_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .lcd_on    (lcd_on),
    .mode      (mode),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .vid_rd_en (vid_rd_en),
    .vid_wr_en (vid_wr_en),
    .vid_addr  (vid_addr),
    .vid_rdata (vid_rdata),
    .spr_rd_en (spr_rd_en),
    .spr_wr_en (spr_wr_en),
    .spr_addr  (spr_addr),
    .spr_rdata (spr_rdata),
    .mem_wdata (mem_wdata),
    .ext_rdata (ext_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h addr=0x%0h mode=%0d lcd=%0b",
               req, act, exp, cpu_addr, mode, lcd_on);
    end
  endtask

  function automatic bit in_vid(input logic [15:0] a);
    return a >= 16'h8000 && a <= 16'h9FFF;
  endfunction

  function automatic bit in_spr(input logic [15:0] a);
    return a >= 16'hFE00 && a <= 16'hFE9F;
  endfunction

  function automatic bit vid_ok(input bit lcd, input logic [1:0] m);
    return !lcd || m != 2'd3;
  endfunction

  function automatic bit spr_ok(input bit lcd, input logic [1:0] m);
    return !lcd || m < 2'd2;
  endfunction

  function automatic string gate_tag(input bit lcd, input logic [1:0] m);
    if (!lcd)       return "R10";
    if (m == 2'd3)  return "R5";
    if (m == 2'd2)  return "R4";
    return "R3";
  endfunction

  function automatic logic [15:0] pick_addr();
    int k;
    k = $urandom_range(0, 9);
    case (k)
      0, 1, 2: return 16'h8000 + 16'($urandom_range(0, 16'h1FFF));
      3, 4, 5: return 16'hFE00 + 16'($urandom_range(0, 16'h9F));
      6: begin
        case ($urandom_range(0, 7))
          0: return 16'h7FFF;
          1: return 16'h8000;
          2: return 16'h9FFF;
          3: return 16'hA000;
          4: return 16'hFDFF;
          5: return 16'hFE00;
          6: return 16'hFE9F;
          default: return 16'hFEA0;
        endcase
      end
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic step(input logic [15:0] a, input logic [1:0] m, input bit lcd,
                      input bit rd, input bit wr);
    int exp_rd;
    bit v;
    bit s;
    @(negedge clk);
    cpu_addr  = a;
    mode      = m;
    lcd_on    = lcd;
    cpu_rd    = rd;
    cpu_wr    = wr;
    cpu_wdata = 8'($urandom);
    vid_rdata = 8'($urandom);
    spr_rdata = 8'($urandom);
    ext_rdata = 8'($urandom);
    #2;
    v = in_vid(a);
    s = in_spr(a);
    // read data due from the previous strobe
    case (pend_src)
      1: begin exp_rd = vid_rdata; chk("R8 vid readback", cpu_rdata, exp_rd); end
      2: begin exp_rd = spr_rdata; chk("R8 spr readback", cpu_rdata, exp_rd); end
      3: begin exp_rd = 8'hFF;     chk("R7 fill byte",    cpu_rdata, exp_rd); end
      default: begin exp_rd = ext_rdata; chk("R9 ext readback", cpu_rdata, exp_rd); end
    endcase
    chk("R12 write data", mem_wdata, cpu_wdata);
    if (v) begin
      chk("R1 vid offset", vid_addr, a - 16'h8000);
      chk({gate_tag(lcd, m), " vid rd"}, vid_rd_en, rd && vid_ok(lcd, m));
      chk(vid_ok(lcd, m) ? "R3 vid wr" : "R6 vid wr dropped", vid_wr_en, wr && vid_ok(lcd, m));
      chk("R2 spr idle on vid", spr_rd_en | spr_wr_en, 0);
    end else if (s) begin
      chk("R2 spr offset", spr_addr, a - 16'hFE00);
      chk({gate_tag(lcd, m), " spr rd"}, spr_rd_en, rd && spr_ok(lcd, m));
      chk(spr_ok(lcd, m) ? "R3 spr wr" : "R6 spr wr dropped", spr_wr_en, wr && spr_ok(lcd, m));
      chk("R1 vid idle on spr", vid_rd_en | vid_wr_en, 0);
    end else begin
      chk("R9 no enables outside", {vid_rd_en, vid_wr_en, spr_rd_en, spr_wr_en}, 0);
    end
    if (rd) begin
      if (v)      pend_src = vid_ok(lcd, m) ? 1 : 3;
      else if (s) pend_src = spr_ok(lcd, m) ? 2 : 3;
      else        pend_src = 0;
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks   = 0;
    failures = 0;
    pend_src = 0;
    void'($urandom(32'd20251));
    rst_n     = 1'b0;
    lcd_on    = 1'b1;
    mode      = 2'd0;
    cpu_addr  = 16'h0000;
    cpu_rd    = 1'b0;
    cpu_wr    = 1'b0;
    cpu_wdata = 8'h00;
    vid_rdata = 8'h11;
    spr_rdata = 8'h22;
    ext_rdata = 8'h5A;
    repeat (3) @(negedge clk);
    #2;
    chk("R11 reset rdata", cpu_rdata, 8'h5A);
    chk("R11 reset enables", {vid_rd_en, vid_wr_en, spr_rd_en, spr_wr_en}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    ext_rdata = 8'hC3;
    #2;
    chk("R11 rdata after reset", cpu_rdata, 8'hC3);

    // directed corners
    step(16'h8000, 2'd3, 1'b1, 1'b0, 1'b1);  // R5/R6 vram write in transfer
    step(16'h9FFF, 2'd3, 1'b1, 1'b1, 1'b0);  // R7 blocked read
    step(16'h9FFF, 2'd2, 1'b1, 1'b1, 1'b0);  // R4 vram open in search
    step(16'hFE00, 2'd2, 1'b1, 1'b1, 1'b1);  // R4 spr locked
    step(16'hFE9F, 2'd1, 1'b1, 1'b1, 1'b1);  // R3 vblank open
    step(16'hFEA0, 2'd3, 1'b1, 1'b1, 1'b1);  // R9 just above sprite table
    step(16'h7FFF, 2'd0, 1'b1, 1'b1, 1'b0);  // R9 just below vram
    step(16'hFE50, 2'd3, 1'b0, 1'b1, 1'b1);  // R10 display off
    step(16'hA000, 2'd0, 1'b1, 1'b0, 1'b0);  // idle, hold previous source
    step(16'h8123, 2'd0, 1'b1, 1'b0, 1'b0);  // R8 hold over idle
    step(16'h8123, 2'd3, 1'b0, 1'b1, 1'b0);  // R10 vram read with display off
    step(16'h0000, 2'd0, 1'b1, 1'b0, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      step(pick_addr(), 2'($urandom), ($urandom_range(0, 4) != 0),
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end
    step(16'h0000, 2'd0, 1'b1, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule